// File: doc/BRIEF.md
# SDRAM Command and Power-Up Sequencer

This block sits between a host and a single-rank SDR SDRAM with a 16-bit bus. The host brings the memory up one step at a time by writing command words. The usual order is: raise clock-enable, let the host wait at least 100 µs, precharge all banks, run eight auto-refreshes, load the mode register (value 0x0220: one-beat bursts, sequential, CAS latency 2, single-location writes), then start the refresh timer. For each word the block places the matching control pattern on the memory pins. It then holds a busy flag until the command and its required idle gap are complete.

The periodic refresh timer is programmed with a reload count. For a 100 MHz memory clock the count is typically 0x603. Each expiry produces an all-bank auto-refresh. An expiry that arrives while another command is running is remembered and issued as soon as the sequencer is free. The row-cycle, precharge and load-mode gaps are parameters in memory clocks. The address is 13 bits wide and there are two bank-address bits, which cover a 12-row-bit, 8-column-bit, four-bank device.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, sd_cke is 0, sd_ras_n, sd_cas_n and sd_we_n are 1, sd_cs_n is all 0, busy is 0 and precharged is 0.
- R2: The command word has these fields:
  - bits 2:0 hold the operation: 1 clock-enable, 2 precharge-all, 3 auto-refresh, 4 load-mode, 5 set-refresh-timer.
  - bits 4:3 select the target: bit 3 drives sd_cs_n[0] and bit 4 drives sd_cs_n[1].
  - bits 8:5 hold the refresh count minus one.
  - bits 21:9 hold the 13-bit value.
  
  A word is accepted on a clock where cmd_valid is 1 and busy is 0. Its pin pattern appears in the next cycle with the selected chip selects low and the others high.
- R3: Clock-enable raises sd_cke one cycle after acceptance, and sd_cke stays high. It puts no command pattern on the pins and holds busy for 1 cycle.
- R4: Precharge-all drives ras_n=0, cas_n=1, we_n=0 and sd_addr[10]=1. busy falls T_RP cycles after the command cycle.
- R5: Auto-refresh drives ras_n=0, cas_n=0, we_n=1, count+1 times. Successive refreshes start T_RC cycles apart, and busy falls T_RC cycles after the last one.
- R6: Load-mode drives ras_n=0, cas_n=0, we_n=0, with sd_addr equal to the word's value and sd_ba equal to 0. busy falls T_MRD cycles after the command cycle.
- R7: In every cycle without a command, the pins carry NOP: all chip selects low and ras_n, cas_n and we_n high.
- R8: A word written while busy is 1 is dropped. It produces no pin pattern and no state change.
- R9: A word is ignored, leaving busy at 0 and the pins at NOP, if its operation code is 0, 6 or 7, or if its target field is 0.
- R10: Set-refresh-timer with a value V greater than 0 produces an auto-refresh on all chip selects every V+1 cycles. A value of 0 stops the timer.
- R11: A refresh that falls due while a command is running keeps busy high. It is issued one cycle after the running command's gap ends, so the next refresh starts T_RC+1 cycles after the last one of a host burst.
- R12: precharged becomes 1 when a precharge-all completes. It becomes 0 when any other command completes, including a refresh started by the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Operation, target, refresh count minus one, value |
| busy | output | 1 | A command, its gap or a pending refresh is in progress |
| precharged | output | 1 | The last completed command was precharge-all |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |

## Verification
Most corruptions of the gap counter or the repeat count show up within a few cycles. They appear as a refresh spacing other than T_RC, a busy window of the wrong length, or the wrong number of refreshes in a burst. A lost or stuck pending-refresh flag shows only after the timer's next expiry. The bench therefore times the refresh that follows a long host burst against the timer phase. A wrong latched operation shows as a precharged flag that disagrees with the last command seen on the pins.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 3'd0,
    OP_CKE    = 3'd1,
    OP_PALL   = 3'd2,
    OP_AREF   = 3'd3,
    OP_LMR    = 3'd4,
    OP_SETREF = 3'd5
  } seq_op_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rcw_t;

  localparam rcw_t RCW_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam rcw_t RCW_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam rcw_t RCW_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam rcw_t RCW_LMR  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic logic op_known(logic [OP_W-1:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic logic op_on_bus(seq_op_e op);
    return (op == OP_PALL) || (op == OP_AREF) || (op == OP_LMR);
  endfunction

endpackage

// File: rtl/seq_refresh.sv
module seq_refresh #(
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] load_val,
  output logic          due
);

  logic          en_q;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] reload_q;
  logic          due_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
      due_q    <= 1'b0;
    end else if (load) begin
      en_q     <= (load_val != '0);
      cnt_q    <= load_val;
      reload_q <= load_val;
      due_q    <= 1'b0;
    end else if (en_q) begin
      if (cnt_q == '0) begin
        due_q <= 1'b1;
        cnt_q <= reload_q;
      end else begin
        due_q <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      due_q <= 1'b0;
    end
  end

  assign due = due_q;

  // R10: expiries are separated by at least one idle cycle
  a_r10_due_gap: assert property (@(posedge clk) disable iff (rst)
    due_q |=> !due_q);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CNT_W  = 4,
  parameter int VAL_W  = 13,
  parameter int RW     = 13,
  parameter int TW     = 4,
  parameter int T_RP   = 2,
  parameter int T_RC   = 7,
  parameter int T_MRD  = 2,
  localparam int TGT_LO = OP_W,
  localparam int CNT_LO = TGT_LO + NUM_CS,
  localparam int VAL_LO = CNT_LO + CNT_W,
  localparam int CMD_W  = VAL_LO + VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              due,
  output logic              issue_vld,
  output seq_op_e           issue_op,
  output logic [NUM_CS-1:0] issue_tgt,
  output logic [VAL_W-1:0]  issue_val,
  output logic              tmr_load,
  output logic [RW-1:0]     tmr_val,
  output logic              busy_o,
  output logic              prech_o
);

  logic [OP_W-1:0]   w_code;
  seq_op_e           w_op;
  logic [NUM_CS-1:0] w_tgt;
  logic [CNT_W-1:0]  w_cnt;
  logic [VAL_W-1:0]  w_val;

  logic              busy_q, pend_q, prech_q;
  seq_op_e           op_q;
  logic [NUM_CS-1:0] tgt_q;
  logic [VAL_W-1:0]  val_q;
  logic [CNT_W-1:0]  reps_q;
  logic [TW-1:0]     wcnt_q;

  logic accept_host, take_ref, repeat_now;

  assign w_code = cmd_word[OP_W-1:0];
  assign w_op   = seq_op_e'(w_code);
  assign w_tgt  = cmd_word[TGT_LO +: NUM_CS];
  assign w_cnt  = cmd_word[CNT_LO +: CNT_W];
  assign w_val  = cmd_word[VAL_LO +: VAL_W];

  function automatic logic [TW-1:0] gap_m1(seq_op_e op);
    case (op)
      OP_PALL: return TW'(T_RP - 1);
      OP_AREF: return TW'(T_RC - 1);
      OP_LMR:  return TW'(T_MRD - 1);
      default: return '0;
    endcase
  endfunction

  assign accept_host = cmd_valid && !busy_q && !pend_q &&
                       op_known(w_code) && (w_tgt != '0);
  assign take_ref    = !busy_q && pend_q;
  assign repeat_now  = busy_q && (wcnt_q == '0) && (reps_q != '0);

  always_comb begin
    issue_vld = accept_host || take_ref || repeat_now;
    if (take_ref) begin
      issue_op  = OP_AREF;
      issue_tgt = {NUM_CS{1'b1}};
      issue_val = '0;
    end else if (accept_host) begin
      issue_op  = w_op;
      issue_tgt = w_tgt;
      issue_val = w_val;
    end else begin
      issue_op  = op_q;
      issue_tgt = tgt_q;
      issue_val = val_q;
    end
  end

  assign tmr_load = accept_host && (w_op == OP_SETREF);
  assign tmr_val  = w_val[RW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      prech_q <= 1'b0;
      op_q    <= OP_NONE;
      tgt_q   <= '0;
      val_q   <= '0;
      reps_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      pend_q <= due || (pend_q && !take_ref);
      if (issue_vld) begin
        busy_q <= 1'b1;
        wcnt_q <= gap_m1(issue_op);
        op_q   <= issue_op;
        tgt_q  <= issue_tgt;
        val_q  <= issue_val;
        if (accept_host)
          reps_q <= (w_op == OP_AREF) ? w_cnt : '0;
        else if (take_ref)
          reps_q <= '0;
        else
          reps_q <= reps_q - 1'b1;
      end else if (busy_q && (wcnt_q != '0)) begin
        wcnt_q <= wcnt_q - 1'b1;
      end else if (busy_q) begin
        busy_q  <= 1'b0;
        prech_q <= (op_q == OP_PALL);
      end
    end
  end

  assign busy_o  = busy_q || pend_q;
  assign prech_o = prech_q;

  // R11: a pending refresh survives until the running command is over
  a_r11_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (pend_q && busy_q) |=> pend_q);

  // R8: nothing replaces the running operation inside its gap
  a_r8_op_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (wcnt_q != '0)) |=> $stable(op_q) && $stable(val_q));

  // R5: each repeat consumes exactly one count
  a_r5_reps_down: assert property (@(posedge clk) disable iff (rst)
    repeat_now |=> (reps_q == $past(reps_q) - 1'b1) && (op_q == OP_AREF));

endmodule

// File: rtl/seq_pins.sv
module seq_pins
  import sdram_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int A_W    = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_vld,
  input  seq_op_e           issue_op,
  input  logic [NUM_CS-1:0] issue_tgt,
  input  logic [A_W-1:0]    issue_val,
  output logic              sd_cke,
  output logic [NUM_CS-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [A_W-1:0]    sd_addr
);

  localparam int A10 = 10;

  logic           on_bus;
  rcw_t           rcw_d, rcw_q;
  logic [A_W-1:0] addr_d;
  logic           cke_q;
  logic [A_W-1:0] addr_q;
  logic [BA_W-1:0] ba_q;

  assign on_bus = issue_vld && op_on_bus(issue_op);

  always_comb begin
    rcw_d  = RCW_NOP;
    addr_d = '0;
    if (on_bus) begin
      case (issue_op)
        OP_PALL: begin
          rcw_d       = RCW_PALL;
          addr_d[A10] = 1'b1;
        end
        OP_AREF: rcw_d = RCW_AREF;
        OP_LMR: begin
          rcw_d  = RCW_LMR;
          addr_d = issue_val;
        end
        default: rcw_d = RCW_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      rcw_q  <= RCW_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      if (issue_vld && (issue_op == OP_CKE))
        cke_q <= 1'b1;
      rcw_q  <= rcw_d;
      addr_q <= addr_d;
      ba_q   <= '0;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic cs_q;
    always_ff @(posedge clk) begin
      if (rst)
        cs_q <= 1'b0;
      else
        cs_q <= on_bus ? !issue_tgt[i] : 1'b0;
    end
    assign sd_cs_n[i] = cs_q;
  end

  assign sd_cke   = cke_q;
  assign sd_ras_n = rcw_q.ras_n;
  assign sd_cas_n = rcw_q.cas_n;
  assign sd_we_n  = rcw_q.we_n;
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;

  // R3: clock enable never drops once raised
  a_r3_cke_sticky: assert property (@(posedge clk) disable iff (rst)
    sd_cke |=> sd_cke);

  // R4: precharge-all carries the all-banks address bit
  a_r4_pall_a10: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[A10]);

  // R6: load-mode always addresses bank 0
  a_r6_lmr_ba0: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_ba == '0));

  // R2: a real command always reaches at least one chip select
  a_r2_cs_sel: assert property (@(posedge clk) disable iff (rst)
    (!sd_ras_n || !sd_cas_n || !sd_we_n) |-> (sd_cs_n != {NUM_CS{1'b1}}));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int A_W    = 13,
  parameter int BA_W   = 2,
  parameter int CNT_W  = 4,
  parameter int TW     = 4,
  parameter int T_RP   = 2,
  parameter int T_RC   = 7,
  parameter int T_MRD  = 2,
  localparam int RW    = A_W,
  localparam int CMD_W = OP_W + NUM_CS + CNT_W + A_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              busy,
  output logic              precharged,
  output logic              sd_cke,
  output logic [NUM_CS-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [A_W-1:0]    sd_addr
);

  initial begin
    if (A_W <= 10) $error("address bus too narrow for the all-banks bit");
    if (T_RP > (1 << TW) || T_RC > (1 << TW) || T_MRD > (1 << TW))
      $error("a gap does not fit the gap counter");
    if (T_RP < 1 || T_RC < 1 || T_MRD < 1) $error("gaps must be at least 1");
  end

  logic              due;
  logic              issue_vld;
  seq_op_e           issue_op;
  logic [NUM_CS-1:0] issue_tgt;
  logic [A_W-1:0]    issue_val;
  logic              tmr_load;
  logic [RW-1:0]     tmr_val;

  seq_refresh #(.RW(RW)) u_refresh (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .due      (due)
  );

  seq_ctrl #(
    .NUM_CS (NUM_CS),
    .CNT_W  (CNT_W),
    .VAL_W  (A_W),
    .RW     (RW),
    .TW     (TW),
    .T_RP   (T_RP),
    .T_RC   (T_RC),
    .T_MRD  (T_MRD)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .due       (due),
    .issue_vld (issue_vld),
    .issue_op  (issue_op),
    .issue_tgt (issue_tgt),
    .issue_val (issue_val),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .busy_o    (busy),
    .prech_o   (precharged)
  );

  seq_pins #(
    .NUM_CS (NUM_CS),
    .A_W    (A_W),
    .BA_W   (BA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .issue_vld (issue_vld),
    .issue_op  (issue_op),
    .issue_tgt (issue_tgt),
    .issue_val (issue_val),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr)
  );

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_RP  = 2;
  localparam int T_RC  = 7;
  localparam int T_MRD = 2;
  localparam int LOGN  = 32;

  localparam logic [2:0] C_CKE = 3'd1, C_PALL = 3'd2, C_AREF = 3'd3,
                         C_LMR = 3'd4, C_SET = 3'd5;
  localparam int K_PALL = 1, K_AREF = 2, K_LMR = 3, K_BAD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [21:0] cmd_word = '0;
  logic busy, precharged, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n, sd_ba;
  logic [12:0] sd_addr;

  sdram_cmd_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .precharged(precharged), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // memory stub: logs every command seen on the pins
  int n_log = 0;
  int nop_bad = 0;
  int lg_kind [LOGN];
  int lg_cyc  [LOGN];
  logic [12:0] lg_addr [LOGN];
  logic [1:0]  lg_ba   [LOGN];
  logic [1:0]  lg_cs   [LOGN];

  always @(negedge clk) begin
    if (!rst) begin
      if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111) begin
        if (sd_cs_n != 2'b00) nop_bad <= nop_bad + 1;
      end else if (n_log < LOGN) begin
        case ({sd_ras_n, sd_cas_n, sd_we_n})
          3'b010:  lg_kind[n_log] <= K_PALL;
          3'b001:  lg_kind[n_log] <= K_AREF;
          3'b000:  lg_kind[n_log] <= K_LMR;
          default: lg_kind[n_log] <= K_BAD;
        endcase
        lg_cyc[n_log]  <= cyc;
        lg_addr[n_log] <= sd_addr;
        lg_ba[n_log]   <= sd_ba;
        lg_cs[n_log]   <= sd_cs_n;
        n_log <= n_log + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    n_log = 0;
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] tgt,
                      input logic [3:0] cnt, input logic [12:0] val,
                      output int c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {val, cnt, tgt, op};
    c = cyc + 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic wait_idle(output int t);
    t = -1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic wait_logs(input int n, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (n_log >= n) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sd_cke == 1'b0, "R1 cke", int'(sd_cke), 0);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 rcw",
          int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    check(sd_cs_n == 2'b00, "R1 cs_n", int'(sd_cs_n), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(precharged == 1'b0, "R1 precharged", int'(precharged), 0);
  endtask

  task automatic t_cke();
    int c, t;
    clear_log();
    send(C_CKE, 2'b01, 4'd0, 13'd0, c);
    wait_idle(t);
    check(t - c == 1, "R3 busy length", t - c, 1);
    check(sd_cke == 1'b1, "R3 cke high", int'(sd_cke), 1);
    check(n_log == 0, "R3 no bus command", n_log, 0);
  endtask

  task automatic t_pall();
    int c, t;
    clear_log();
    send(C_PALL, 2'b01, 4'd0, 13'd0, c);
    wait_idle(t);
    check(n_log == 1, "R4 count", n_log, 1);
    check(lg_kind[0] == K_PALL, "R4 pattern", lg_kind[0], K_PALL);
    check(lg_cyc[0] == c, "R2 latency", lg_cyc[0], c);
    check(lg_addr[0][10] == 1'b1, "R4 A10", int'(lg_addr[0][10]), 1);
    check(lg_cs[0] == 2'b10, "R2 target cs", int'(lg_cs[0]), 2);
    check(t - c == T_RP, "R4 busy gap", t - c, T_RP);
    check(precharged == 1'b1, "R12 precharged set", int'(precharged), 1);
  endtask

  task automatic t_aref_burst();
    int c, t;
    clear_log();
    send(C_AREF, 2'b11, 4'd7, 13'd0, c);
    wait_idle(t);
    check(n_log == 8, "R5 refresh count", n_log, 8);
    for (int k = 0; k < 8; k++) begin
      check(lg_kind[k] == K_AREF, "R5 pattern", lg_kind[k], K_AREF);
      check(lg_cyc[k] == c + k * T_RC, "R5 spacing", lg_cyc[k], c + k * T_RC);
    end
    check(lg_cs[0] == 2'b00, "R2 both cs", int'(lg_cs[0]), 0);
    check(t == c + 7 * T_RC + T_RC, "R5 busy end", t, c + 8 * T_RC);
    check(precharged == 1'b0, "R12 precharged clear", int'(precharged), 0);
  endtask

  task automatic t_reject();
    int c, c2, t;
    clear_log();
    send(C_PALL, 2'b01, 4'd0, 13'd0, c);
    send(C_LMR, 2'b01, 4'd0, 13'h0155, c2);
    wait_idle(t);
    repeat (4) @(negedge clk);
    check(n_log == 1, "R8 dropped word", n_log, 1);
    check(precharged == 1'b1, "R8 state unchanged", int'(precharged), 1);
  endtask

  task automatic t_ignore();
    int c;
    int bsy = 0;
    clear_log();
    send(3'd0, 2'b01, 4'd0, 13'd0, c);
    if (busy) bsy++;
    send(3'd6, 2'b01, 4'd0, 13'd0, c);
    if (busy) bsy++;
    send(C_LMR, 2'b00, 4'd0, 13'h0220, c);
    if (busy) bsy++;
    repeat (4) @(negedge clk);
    check(bsy == 0, "R9 busy stays low", bsy, 0);
    check(n_log == 0, "R9 no pins", n_log, 0);
    check(precharged == 1'b1, "R9 state unchanged", int'(precharged), 1);
  endtask

  task automatic t_lmr();
    int c, t;
    clear_log();
    send(C_LMR, 2'b01, 4'd0, 13'h0220, c);
    wait_idle(t);
    check(n_log == 1 && lg_kind[0] == K_LMR, "R6 pattern", lg_kind[0], K_LMR);
    check(lg_addr[0] == 13'h0220, "R6 address", int'(lg_addr[0]), 'h220);
    check(lg_ba[0] == 2'b00, "R6 bank", int'(lg_ba[0]), 0);
    check(t - c == T_MRD, "R6 busy gap", t - c, T_MRD);
    check(precharged == 1'b0, "R12 cleared by load", int'(precharged), 0);
  endtask

  task automatic t_timer();
    int c, t;
    send(C_PALL, 2'b01, 4'd0, 13'd0, c);
    wait_idle(t);
    send(C_SET, 2'b01, 4'd0, 13'd40, c);
    wait_idle(t);
    clear_log();
    wait_logs(3, 300);
    check(n_log >= 3, "R10 refreshes seen", n_log, 3);
    check(lg_cyc[1] - lg_cyc[0] == 41, "R10 interval", lg_cyc[1] - lg_cyc[0], 41);
    check(lg_cyc[2] - lg_cyc[1] == 41, "R10 interval", lg_cyc[2] - lg_cyc[1], 41);
    check(lg_kind[0] == K_AREF && lg_cs[0] == 2'b00, "R10 all-cs refresh",
          int'(lg_cs[0]), 0);
    check(precharged == 1'b0, "R12 cleared by timer refresh", int'(precharged), 1'b0);
  endtask

  task automatic t_pending();
    int c, t;
    clear_log();
    wait_logs(1, 100);
    wait_idle(t);
    send(C_AREF, 2'b11, 4'd7, 13'd0, c);
    wait_logs(10, 200);
    check(n_log >= 10, "R11 refresh total", n_log, 10);
    check(lg_cyc[8] - lg_cyc[1] == 7 * T_RC, "R11 burst intact",
          lg_cyc[8] - lg_cyc[1], 7 * T_RC);
    check(lg_cyc[9] - lg_cyc[8] == T_RC + 1, "R11 pending issue",
          lg_cyc[9] - lg_cyc[8], T_RC + 1);
    check(lg_cs[9] == 2'b00, "R11 all-cs", int'(lg_cs[9]), 0);
  endtask

  task automatic t_disable();
    int c, t;
    wait_idle(t);
    send(C_SET, 2'b01, 4'd0, 13'd0, c);
    repeat (10) @(negedge clk);
    clear_log();
    repeat (150) @(negedge clk);
    check(n_log == 0, "R10 timer stopped", n_log, 0);
    check(busy == 1'b0, "R10 idle after stop", int'(busy), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      check(nop_bad == 0, "R7 nop pattern", nop_bad, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_cke();
    t_pall();
    t_aref_burst();
    t_reject();
    t_ignore();
    t_lmr();
    t_timer();
    t_pending();
    t_disable();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule